// File: doc/BRIEF.md
# MSI-X Vector Mask and Pending Controller

This block keeps a small table of message-signalled interrupt vectors, each with a message address, a data word and a control word carrying a per-vector mask bit. It also keeps the function-wide enable and mask-all bits. From these it works out whether each vector is masked. An interrupt request on a masked vector is parked in a pending bit. A request on an unmasked vector is sent right away. When a vector goes from masked to unmasked while its pending bit is set, the block clears the bit and sends that vector's stored message.

Software fills the table through a byte-addressed dword write port and drives the enable and mask-all bits through a separate control write port. Peripheral logic raises one-cycle requests on per-vector inputs. Messages leave one per cycle on an output that carries the vector index, the 64-bit address and the 32-bit data. While message signalling is enabled, the block also holds a legacy level-interrupt line low.

Top module: `msix_mask_ctrl`

## Requirements
- R1: After reset the function mask reads 1, every vector's control mask bit is 1, all pending bits are 0, no message is offered and message signalling is disabled.
- R2: The function mask output is 1 whenever the enable bit is 0 or the mask-all bit is 1, and 0 only when enable is 1 and mask-all is 0.
- R3: A vector is masked when the function mask is 1 or bit 0 of its control dword is 1. The control dword is dword 3 of the vector's 16-byte entry.
- R4: A request on a masked vector sets that vector's pending bit and sends no message.
- R5: A request on an unmasked vector offers a message in the next cycle. The message carries the vector index, the address {dword 1, dword 0} and the data dword 2 of that vector's entry, and the pending bits do not change.
- R6: When a vector goes from masked to unmasked with its pending bit set, the pending bit clears and the vector's message is sent. A write that leaves a vector's masked state unchanged neither sends nor changes its pending bit.
- R7: A control write re-evaluates every vector against the previous function mask. A write that leaves the block disabled, or that leaves the function mask unchanged, sends nothing, and pending bits are kept.
- R8: Sends that become due in the same cycle leave one per cycle, lowest vector index first.
- R9: Table writes ignore address bits [1:0]. Address bits [3:2] select the dword, and the upper bits divided by 16 give the vector index. A write whose vector index is at or above the implemented count changes nothing.
- R10: While message signalling is enabled, the legacy interrupt output is 0. Otherwise it follows its input.
- R11: Pending bits are packed eight per byte into (n+7)/8 bytes. Bit i belongs to vector i, and the padding bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_wr_en | input | 1 | Table dword write strobe |
| tbl_wr_addr | input | ADDR_W | Byte offset of the table write |
| tbl_wr_data | input | 32 | Table write data |
| ctl_wr_en | input | 1 | Control write strobe |
| ctl_enable | input | 1 | New value of the message-signalling enable bit |
| ctl_mask_all | input | 1 | New value of the mask-all bit |
| irq_req | input | NUM_VEC | Per-vector interrupt request pulses |
| intx_in | input | 1 | Legacy level interrupt from the function |
| intx_out | output | 1 | Legacy level interrupt, gated by enable |
| func_mask | output | 1 | Current function-level mask |
| pend_bits | output | 8*((NUM_VEC+7)/8) | Packed pending-bit array |
| msg_valid | output | 1 | A message is offered in this cycle |
| msg_vector | output | 5 | Vector index of the offered message |
| msg_addr | output | 64 | Message address of that vector |
| msg_data | output | 32 | Message data of that vector |

## Verification
In one cycle, a table write can unmask a vector that holds a pending bit while a request arrives on a different vector that is already unmasked. Both sends then become due together. The bench provokes this by driving the control-dword write and the request pulse in the same cycle. It checks that the two messages leave on consecutive cycles, lowest index first, and that only the unmasked vector's pending bit clears. A control write that drops the function mask for several pending vectors at once is judged the same way, against the expected index order and the expected remaining pending pattern.

// File: rtl/msix_pkg.sv
// Shared constants and types for the MSI-X mask and pending controller.
// Assumes a 16-byte table entry laid out as address low, address high,
// data, and control dwords, with the per-vector mask in bit 0 of control.
package msix_pkg;

    localparam int unsigned MSIX_MAX_VEC   = 32;
    localparam int unsigned ENTRY_BYTES    = 16;
    localparam int unsigned VEC_IDX_W      = 5;
    localparam logic [1:0]  DW_ADDR_LO     = 2'd0;
    localparam logic [1:0]  DW_ADDR_HI     = 2'd1;
    localparam logic [1:0]  DW_DATA        = 2'd2;
    localparam logic [1:0]  DW_CTRL        = 2'd3;
    localparam int unsigned CTRL_MASK_BIT  = 0;

    typedef logic [31:0] dword_t;
    typedef logic [VEC_IDX_W-1:0] vec_idx_t;

endpackage

// File: rtl/msix_vec_table.sv
// Vector table storage. Decodes dword writes into per-vector entries and
// presents the current and next-cycle mask bit of each vector, plus the
// address and data of one selected vector.
// Assumes ADDR_W >= 9, so that 32 entries can be addressed, and NUM_VEC <= 32.
module msix_vec_table
    import msix_pkg::*;
#(
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  dword_t             wr_data,
    input  vec_idx_t           sel_idx,
    output logic [NUM_VEC-1:0] vmask_q,
    output logic [NUM_VEC-1:0] vmask_d,
    output logic [63:0]        sel_addr,
    output dword_t             sel_data
);

    localparam int unsigned IDX_W = ADDR_W - 4;

    logic [IDX_W-1:0]        vec_idx;
    logic [1:0]              dw_sel;
    logic                    hit;
    logic                    addr_low_unused;
    logic [NUM_VEC*32-1:0]   lo_flat;
    logic [NUM_VEC*32-1:0]   hi_flat;
    logic [NUM_VEC*32-1:0]   dat_flat;

    // Split the byte offset: entry index, dword within entry, dropped byte lanes.
    assign vec_idx         = wr_addr[ADDR_W-1:4];
    assign dw_sel          = wr_addr[3:2];
    assign addr_low_unused = ^wr_addr[1:0];
    assign hit             = wr_en && (32'(vec_idx) < 32'(NUM_VEC));

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_ent
        logic   wsel;
        dword_t lo_q;
        dword_t hi_q;
        dword_t dat_q;
        logic   msk_q;

        assign wsel = hit && (vec_idx == IDX_W'(i));

        // Hold one entry; reset leaves the vector masked.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q  <= '0;
                hi_q  <= '0;
                dat_q <= '0;
                msk_q <= 1'b1;
            end else if (wsel) begin
                unique case (dw_sel)
                    DW_ADDR_LO: lo_q  <= wr_data;
                    DW_ADDR_HI: hi_q  <= wr_data;
                    DW_DATA:    dat_q <= wr_data;
                    default:    msk_q <= wr_data[CTRL_MASK_BIT];
                endcase
            end
        end

        assign lo_flat[i*32 +: 32]  = lo_q;
        assign hi_flat[i*32 +: 32]  = hi_q;
        assign dat_flat[i*32 +: 32] = dat_q;
        assign vmask_q[i]           = msk_q;
        assign vmask_d[i]           = (wsel && dw_sel == DW_CTRL) ? wr_data[CTRL_MASK_BIT] : msk_q;
    end

    // Pick the entry of the vector being offered on the message port.
    always_comb begin
        sel_addr = '0;
        sel_data = '0;
        for (int i = 0; i < NUM_VEC; i++) begin
            if (sel_idx == VEC_IDX_W'(i)) begin
                sel_addr = {hi_flat[i*32 +: 32], lo_flat[i*32 +: 32]};
                sel_data = dat_flat[i*32 +: 32];
            end
        end
    end

    // R9
    oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit) |=> $stable(vmask_q));

endmodule

// File: rtl/msix_mask_core.sv
// Mask evaluation and pending logic. Holds the enable and mask-all bits,
// the pending array and the queue of due sends. Each cycle it compares the
// masked state of every vector before and after this cycle's writes, and
// acts only on a masked-to-unmasked change.
// Assumes one-cycle request pulses and a one-hot grant from the arbiter.
module msix_mask_core #(
    parameter int unsigned NUM_VEC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic               ctl_enable,
    input  logic               ctl_mask_all,
    input  logic [NUM_VEC-1:0] vmask_q,
    input  logic [NUM_VEC-1:0] vmask_d,
    input  logic [NUM_VEC-1:0] irq,
    input  logic [NUM_VEC-1:0] grant,
    output logic               en_q,
    output logic               fmask,
    output logic [NUM_VEC-1:0] pend_q,
    output logic [NUM_VEC-1:0] sreq_q
);

    logic               ma_q;
    logic               en_d;
    logic               ma_d;
    logic               fmask_new;
    logic [NUM_VEC-1:0] was_masked;
    logic [NUM_VEC-1:0] is_masked;
    logic [NUM_VEC-1:0] unmask;
    logic [NUM_VEC-1:0] pend_d;
    logic [NUM_VEC-1:0] sreq_d;

    // Function mask before and after this cycle's control write.
    always_comb begin
        en_d      = ctl_wr ? ctl_enable   : en_q;
        ma_d      = ctl_wr ? ctl_mask_all : ma_q;
        fmask     = !en_q || ma_q;
        fmask_new = !en_d || ma_d;
    end

    // Per-vector state before and after, and the resulting transitions.
    always_comb begin
        was_masked = {NUM_VEC{fmask}}     | vmask_q;
        is_masked  = {NUM_VEC{fmask_new}} | vmask_d;
        unmask     = was_masked & ~is_masked;
        pend_d     = (pend_q & ~unmask) | (irq & is_masked);
        sreq_d     = (sreq_q & ~grant) | (unmask & pend_q) | (irq & ~is_masked);
    end

    // Control bits: reset leaves the function disabled, hence masked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            ma_q <= 1'b0;
        end else begin
            en_q <= en_d;
            ma_q <= ma_d;
        end
    end

    // Pending array and queue of sends waiting for the message port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            sreq_q <= '0;
        end else begin
            pend_q <= pend_d;
            sreq_q <= sreq_d;
        end
    end

    for (genvar i = 0; i < NUM_VEC; i++) begin : g_chk
        // R6
        unmask_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[i] && was_masked[i] && !is_masked[i]) |=> (!pend_q[i] && sreq_q[i]));
        // R4
        masked_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && is_masked[i]) |=> pend_q[i]);
        // R5
        direct_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (irq[i] && !is_masked[i]) |=> sreq_q[i]);
    end

endmodule

// File: rtl/msix_send_arb.sv
// Fixed-priority picker for due sends: the lowest set request wins.
// Purely combinational; the grant retires the request on the next edge.
module msix_send_arb
    import msix_pkg::*;
#(
    parameter int unsigned NUM_VEC = 8
) (
    input  logic [NUM_VEC-1:0] sreq,
    output logic [NUM_VEC-1:0] grant,
    output logic               valid,
    output vec_idx_t           idx
);

    // Isolate the lowest set request and encode its position.
    always_comb begin
        grant = sreq & ~(sreq - NUM_VEC'(1));
        valid = |sreq;
        idx   = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (sreq[i]) begin
                idx = VEC_IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/msix_mask_ctrl.sv
// Top of the MSI-X vector mask and pending controller. Ties the vector
// table, the mask/pending core and the send picker together, packs the
// pending array into bytes and gates the legacy interrupt line.
// Assumes 1 <= NUM_VEC <= 32 and ADDR_W >= 9.
module msix_mask_ctrl
    import msix_pkg::*;
#(
    parameter int unsigned NUM_VEC = 8,
    parameter int unsigned ADDR_W  = 12,
    localparam int unsigned PBA_BYTES = (NUM_VEC + 7) / 8,
    localparam int unsigned PBA_BITS  = PBA_BYTES * 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_wr_en,
    input  logic [ADDR_W-1:0]   tbl_wr_addr,
    input  logic [31:0]         tbl_wr_data,
    input  logic                ctl_wr_en,
    input  logic                ctl_enable,
    input  logic                ctl_mask_all,
    input  logic [NUM_VEC-1:0]  irq_req,
    input  logic                intx_in,
    output logic                intx_out,
    output logic                func_mask,
    output logic [PBA_BITS-1:0] pend_bits,
    output logic                msg_valid,
    output logic [4:0]          msg_vector,
    output logic [63:0]         msg_addr,
    output logic [31:0]         msg_data
);

    logic [NUM_VEC-1:0] vmask_q;
    logic [NUM_VEC-1:0] vmask_d;
    logic [NUM_VEC-1:0] pend_q;
    logic [NUM_VEC-1:0] sreq_q;
    logic [NUM_VEC-1:0] grant;
    logic               en_q;
    vec_idx_t           pick_idx;

    msix_vec_table #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_wr_en),
        .wr_addr  (tbl_wr_addr),
        .wr_data  (tbl_wr_data),
        .sel_idx  (pick_idx),
        .vmask_q  (vmask_q),
        .vmask_d  (vmask_d),
        .sel_addr (msg_addr),
        .sel_data (msg_data)
    );

    msix_mask_core #(.NUM_VEC(NUM_VEC)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr       (ctl_wr_en),
        .ctl_enable   (ctl_enable),
        .ctl_mask_all (ctl_mask_all),
        .vmask_q      (vmask_q),
        .vmask_d      (vmask_d),
        .irq          (irq_req),
        .grant        (grant),
        .en_q         (en_q),
        .fmask        (func_mask),
        .pend_q       (pend_q),
        .sreq_q       (sreq_q)
    );

    msix_send_arb #(.NUM_VEC(NUM_VEC)) u_arb (
        .sreq  (sreq_q),
        .grant (grant),
        .valid (msg_valid),
        .idx   (pick_idx)
    );

    assign msg_vector = pick_idx;

    // Legacy line is held low while message signalling is on.
    assign intx_out = intx_in && !en_q;

    // Pack pending bits eight per byte; bits past NUM_VEC read zero.
    for (genvar b = 0; b < PBA_BITS; b++) begin : g_pba
        if (b < NUM_VEC) begin : g_live
            assign pend_bits[b] = pend_q[b];
        end else begin : g_pad
            assign pend_bits[b] = 1'b0;
        end
    end

    // R10
    intx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> !intx_out);
    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8
    lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> ((grant & sreq_q) != '0 && (sreq_q & (grant - NUM_VEC'(1))) == '0));
    // R2
    fmask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> func_mask);

endmodule

// File: tb/test_msix_mask_ctrl.sv
module test_msix_mask_ctrl;

    localparam int NV = 6;
    localparam int AW = 12;
    localparam int PB = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tbl_wr_en;
    logic [AW-1:0] tbl_wr_addr;
    logic [31:0]   tbl_wr_data;
    logic          ctl_wr_en;
    logic          ctl_enable;
    logic          ctl_mask_all;
    logic [NV-1:0] irq_req;
    logic          intx_in;
    logic          intx_out;
    logic          func_mask;
    logic [PB-1:0] pend_bits;
    logic          msg_valid;
    logic [4:0]    msg_vector;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    msix_mask_ctrl #(.NUM_VEC(NV), .ADDR_W(AW)) i_msix_mask_ctrl (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
        .ctl_wr_en(ctl_wr_en), .ctl_enable(ctl_enable), .ctl_mask_all(ctl_mask_all),
        .irq_req(irq_req), .intx_in(intx_in), .intx_out(intx_out),
        .func_mask(func_mask), .pend_bits(pend_bits),
        .msg_valid(msg_valid), .msg_vector(msg_vector),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tbl_wr(input int addr, input logic [31:0] data);
        tbl_wr_en   = 1'b1;
        tbl_wr_addr = AW'(addr);
        tbl_wr_data = data;
        tick();
        tbl_wr_en   = 1'b0;
    endtask

    task automatic ctl_wr(input logic en, input logic ma);
        ctl_wr_en    = 1'b1;
        ctl_enable   = en;
        ctl_mask_all = ma;
        tick();
        ctl_wr_en    = 1'b0;
    endtask

    task automatic pulse(input logic [NV-1:0] m);
        irq_req = m;
        tick();
        irq_req = '0;
    endtask

    // Check the offered message against the programmed entry, then let it retire.
    task automatic expect_msg(input string req, input int v);
        check(req, "msg_valid", 64'(msg_valid), 64'd1);
        check(req, "msg_vector", 64'(msg_vector), 64'(v));
        check(req, "msg_addr", msg_addr, {32'(v), 32'h1000_0000 + 32'(v * 16)});
        check(req, "msg_data", 64'(msg_data), 64'(32'hD0 + v));
        tick();
    endtask

    task automatic expect_idle(input string req, input logic [7:0] pend);
        check(req, "msg_valid idle", 64'(msg_valid), 64'd0);
        check(req, "pend_bits", 64'(pend_bits), 64'(pend));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
        ctl_wr_en = 1'b0; ctl_enable = 1'b0; ctl_mask_all = 1'b0;
        irq_req = '0; intx_in = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "func_mask", 64'(func_mask), 64'd1);
        expect_idle("R1", 8'h00);
        check("R10", "intx follows while disabled", 64'(intx_out), 64'd1);

        // Program entries; dword offsets carry stray low bits (R9 alignment)
        for (int v = 0; v < NV; v++) begin
            tbl_wr(v * 16 + 0, 32'h1000_0000 + 32'(v * 16));
            tbl_wr(v * 16 + 4 + 1, 32'(v));
            tbl_wr(v * 16 + 8 + (v % 4), 32'hD0 + 32'(v));
        end

        // R4 / R1: all vectors masked after reset, requests park
        pulse('1);
        expect_idle("R4", 8'h3F);

        // R2 / R10: sweep all control combinations with every control mask bit set
        for (int c = 0; c < 4; c++) begin
            ctl_wr(c[1], c[0]);
            check("R2", "func_mask", 64'(func_mask), 64'(!c[1] || c[0]));
            check("R10", "intx_out", 64'(intx_out), 64'(!c[1]));
            expect_idle("R6", 8'h3F);
        end

        // R3 / R6: clear control bits of 0, 2, 5 under mask-all: no change in state
        ctl_wr(1'b1, 1'b1);
        tbl_wr(0 * 16 + 12, 32'h0);
        tbl_wr(2 * 16 + 12, 32'h0);
        tbl_wr(5 * 16 + 12, 32'hFFFF_FFFE);
        expect_idle("R3", 8'h3F);

        // R7 / R8: dropping mask-all unmasks three pending vectors at once
        ctl_wr(1'b1, 1'b0);
        check("R7", "pend after release", 64'(pend_bits), 64'h1A);
        expect_msg("R8", 0);
        expect_msg("R8", 2);
        expect_msg("R8", 5);
        expect_idle("R8", 8'h1A);

        // R6: unmask vector 3 by its own control dword
        tbl_wr(3 * 16 + 12, 32'h0);
        check("R6", "pend after unmask", 64'(pend_bits), 64'h12);
        expect_msg("R6", 3);
        expect_idle("R6", 8'h12);

        // R5 / R4: sweep requests over every vector
        for (int v = 0; v < NV; v++) begin
            pulse(NV'(1) << v);
            if (v == 1 || v == 4) begin
                expect_idle("R4", 8'h12);
            end else begin
                expect_msg("R5", v);
                expect_idle("R5", 8'h12);
            end
        end

        // R6: rewrite a mask bit that is already set
        tbl_wr(1 * 16 + 12, 32'h1);
        expect_idle("R6", 8'h12);

        // R9 / R11: writes above the vector count, including the pending area
        tbl_wr(6 * 16 + 12, 32'h0);
        tbl_wr(7 * 16 + 12, 32'h0);
        tbl_wr(12'h800, 32'hFFFF_FFFF);
        expect_idle("R9", 8'h12);
        check("R11", "padding bits", 64'(pend_bits[7:6]), 64'd0);

        // R8 / R6: unmask pending vector 1 while vector 2 requests, same cycle
        irq_req = NV'(1) << 2;
        tbl_wr(1 * 16 + 12, 32'h0);
        irq_req = '0;
        check("R6", "pend after joint cycle", 64'(pend_bits), 64'h10);
        expect_msg("R8", 1);
        expect_msg("R8", 2);
        expect_idle("R8", 8'h10);

        // R7: disabled function masks everything; unmasking vector 4 sends nothing
        ctl_wr(1'b0, 1'b0);
        check("R7", "func_mask disabled", 64'(func_mask), 64'd1);
        check("R10", "intx follows", 64'(intx_out), 64'd1);
        pulse(NV'(1) << 0);
        expect_idle("R4", 8'h11);
        tbl_wr(4 * 16 + 12, 32'h0);
        expect_idle("R7", 8'h11);
        ctl_wr(1'b0, 1'b1);
        expect_idle("R7", 8'h11);

        // R7 / R11: enabling releases vectors 0 and 4
        ctl_wr(1'b1, 1'b0);
        check("R11", "pend cleared", 64'(pend_bits), 64'h00);
        expect_msg("R7", 0);
        expect_msg("R7", 4);
        expect_idle("R7", 8'h00);
        check("R10", "intx gated", 64'(intx_out), 64'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule